// File: doc/BRIEF.md
# Resolver Angle Tracking Loop

This block follows the shaft angle of a resolver from demodulated sine and cosine samples. The samples are signed and already free of the carrier. The block holds its own estimate of the angle and of the rotation rate. It corrects both estimates each time a new sample pair arrives. No start command and no wait for a result is involved: every accepted sample pair moves the loop one step, and the angle and rate words are updated on the next clock edge.

For each step the loop forms an error term from two cross products. The sine input is multiplied by the cosine of the present angle estimate. From that, the product of the cosine input and the sine of the estimate is subtracted. For small deviations this equals the angle difference scaled by the input amplitude. The error feeds two integrators in series. The first accumulates a rate estimate. The second accumulates the angle, and it adds a proportional share of the error before it does so. Because of the second integrator, a shaft turning at a steady speed is followed with no lasting lag. The sine and cosine of the estimate come from a 256-entry quarter-wave table that is filled at elaboration. Linear interpolation between table entries gives full resolution at the angle word's least significant bit.

Top module: `resolver_tracker`

## Requirements
- R1: A synchronous reset forces the angle word to 0, the velocity word to 0 and `out_valid` to 0 from the first clock edge at which `rst` is high, whatever `in_valid` is doing.
- R2: While `in_valid` is low the angle and velocity words keep their values, whatever the sample inputs carry.
- R3: The loop error is sin_in·cos(φ) − cos_in·sin(φ), with φ the present angle word. A step whose error is positive raises the velocity word and moves the angle word forward. A step whose error is negative does the opposite.
- R4: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R5: When the input angle stays fixed, the angle word settles within 2 LSB of it. The velocity word then stays below one angle LSB per step in magnitude.
- R6: When the input angle changes by a constant amount each step, in either direction, the loop settles to zero lasting lag. After the step that takes sample n, the angle word is within 2 LSB of the angle of sample n+1. The velocity word is within 0.25 angle LSB per step of the true rate.
- R7: The angle word is 12 bits unsigned, and one LSB is 1/4096 of a turn (angle 0 means sine 0, cosine at full scale). It wraps modulo 4096, so tracking continues without a break when the rotation crosses zero.
- R8: The velocity word is signed and counts angle LSB per step in units of 2^-16, so 65536 means one LSB per step. When the rotation is slower than one LSB per step, the angle word changes by at most one LSB between consecutive steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair strobe; each high cycle advances the loop one step |
| sin_in | input | 16 | Signed demodulated sine sample |
| cos_in | input | 16 | Signed demodulated cosine sample |
| angle_out | output | 12 | Tracked angle, 1/4096 turn per LSB |
| velocity_out | output | 32 | Signed rate estimate, 2^-16 angle LSB per step |
| out_valid | output | 1 | High the cycle after an accepted sample pair |

## Verification
The bench builds the block with its default parameters. These are a 12-bit angle with 16 fractional bits, a proportional shift of 6, an integral shift of 10, and 16-bit samples driven at an amplitude of 16000. At that amplitude the closed-loop poles sit near 0.9. A loop started from rest, from half a turn away, or from a sudden change of speed therefore settles within a few hundred steps. This makes several fixed angles, a forward ramp and a reverse ramp that each cross zero, and a ramp below one LSB per step all fit in a short run. The same settings also let single-step error probes show the direction in which the velocity and the angle move.

// File: rtl/resolver_tracker.sv
`timescale 1ns/1ps
module resolver_tracker #(
  parameter int ANG_W    = 12,
  parameter int FRAC_W   = 16,
  parameter int SAMP_W   = 16,
  parameter int TRIG_W   = 16,
  parameter int TAB_BITS = 8,
  parameter int VEL_W    = 32,
  parameter int KP_SH    = 6,
  parameter int KI_SH    = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] sin_in,
  input  logic signed [SAMP_W-1:0] cos_in,
  output logic [ANG_W-1:0]         angle_out,
  output logic signed [VEL_W-1:0]  velocity_out,
  output logic                     out_valid
);
  localparam int POS_W    = ANG_W + FRAC_W;
  localparam int QTR_W    = ANG_W - 2;
  localparam int INT_W    = QTR_W - TAB_BITS;
  localparam int TAB_N    = 1 << TAB_BITS;
  localparam int PROD_W   = SAMP_W + TRIG_W;
  localparam int ERR_W    = PROD_W + 1;
  localparam longint TRIG_MAX = (64'sd1 <<< (TRIG_W - 1)) - 1;
  localparam logic [QTR_W:0] QEND = 1 << QTR_W;

  // sine of idx * (pi/2) / TAB_N, fixed point Taylor series, scaled to TRIG_MAX
  function automatic logic signed [TRIG_W-1:0] qsin(input int idx);
    longint one, x, x2, t, v;
    one = 64'sd1 <<< 30;
    x   = (longint'(idx) * 64'sd3373259426) / (longint'(TAB_N) * 2);
    x2  = (x * x) >>> 30;
    t   = one;
    t   = one - ((x2 * t) >>> 30) / 110;
    t   = one - ((x2 * t) >>> 30) / 72;
    t   = one - ((x2 * t) >>> 30) / 42;
    t   = one - ((x2 * t) >>> 30) / 20;
    t   = one - ((x2 * t) >>> 30) / 6;
    v   = (x * t) >>> 30;
    v   = (v * TRIG_MAX + (one >>> 1)) >>> 30;
    if (v > TRIG_MAX) v = TRIG_MAX;
    return v[TRIG_W-1:0];
  endfunction

  logic [POS_W-1:0]         pos;
  logic signed [VEL_W-1:0]  vel;
  logic signed [TRIG_W-1:0] qtab [0:TAB_N+1];
  logic signed [TRIG_W-1:0] trig [2];

  for (genvar gi = 0; gi < TAB_N + 2; gi++) begin : g_tab
    assign qtab[gi] = qsin((gi > TAB_N) ? TAB_N : gi);
  end

  assign angle_out    = pos[POS_W-1:FRAC_W];
  assign velocity_out = vel;

  // gk = 0 gives sin(phi); gk = 1 gives sin(phi + quarter turn) = cos(phi)
  for (genvar gk = 0; gk < 2; gk++) begin : g_trig
    logic [ANG_W-1:0]         ph;
    logic [QTR_W:0]           u;
    logic [TAB_BITS:0]        base, nxt;
    logic [INT_W-1:0]         fr;
    logic signed [TRIG_W-1:0] lo, hi, mag;
    logic [TRIG_W-1:0]        d;
    logic [TRIG_W+INT_W-1:0]  prod;
    assign ph   = angle_out + ANG_W'(gk << QTR_W);
    assign u    = ph[ANG_W-2] ? QEND - {1'b0, ph[QTR_W-1:0]} : {1'b0, ph[QTR_W-1:0]};
    assign base = u[QTR_W:INT_W];
    assign nxt  = base + 1'b1;
    assign fr   = u[INT_W-1:0];
    assign lo   = qtab[base];
    assign hi   = qtab[nxt];
    assign d    = hi - lo;
    assign prod = d * fr;
    assign mag  = lo + TRIG_W'(prod >> INT_W);
    assign trig[gk] = ph[ANG_W-1] ? -mag : mag;
  end

  logic signed [PROD_W-1:0] p_sc, p_cs;
  logic signed [ERR_W-1:0]  err;
  logic signed [VEL_W-1:0]  vel_nx;
  logic [POS_W-1:0]         pos_nx;

  assign p_sc   = sin_in * trig[1];
  assign p_cs   = cos_in * trig[0];
  assign err    = ERR_W'(p_sc) - ERR_W'(p_cs);
  assign vel_nx = vel + VEL_W'(err >>> KI_SH);
  assign pos_nx = pos + POS_W'(vel_nx) + POS_W'(err >>> KP_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      vel       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        pos <= pos_nx;
        vel <= vel_nx;
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (angle_out == '0 && velocity_out == '0 && !out_valid));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(angle_out) && $stable(velocity_out)));

  a_r3_positive_error_raises_rate: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (err >>> KI_SH) > 0) |=> velocity_out > $past(velocity_out));

  a_r3_negative_error_lowers_rate: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (err >>> KI_SH) < 0) |=> velocity_out < $past(velocity_out));

  a_r4_valid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r4_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: tb/resolver_tracker_test.sv
`timescale 1ns/1ps
module resolver_tracker_test;
  localparam int AW = 12;
  localparam int SW = 16;
  localparam int VW = 32;
  localparam real AMP  = 16000.0;
  localparam real PI   = 3.14159265358979;
  localparam real TURN = 4096.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] sin_in = '0;
  logic signed [SW-1:0] cos_in = '0;
  logic [AW-1:0] angle_out;
  logic signed [VW-1:0] velocity_out;
  logic out_valid;

  resolver_tracker uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sin_in(sin_in), .cos_in(cos_in),
    .angle_out(angle_out), .velocity_out(velocity_out), .out_valid(out_valid)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int wraps = 0;
  bit have_prev = 1'b0;
  logic [AW-1:0] prev_ang = '0;

  // scoreboard: one entry per accepted sample; mode bit0 angle, bit1 rate, bit2 step size
  real   q_ang[$];
  int    q_mode[$];
  real   q_rate[$];
  real   q_tol[$];
  string q_req[$];

  function automatic real fabs(input real a);
    return (a < 0.0) ? -a : a;
  endfunction

  function automatic real wrapd(input real d);
    real r = d;
    while (r >= 2048.0) r -= TURN;
    while (r < -2048.0) r += TURN;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %f expected %f", req, what, act, exp);
    end
  endtask

  function automatic logic signed [SW-1:0] quant(input real r);
    return SW'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
  endfunction

  task automatic put(input real th);
    real a = 2.0 * PI * th / TURN;
    sin_in = quant(AMP * $sin(a));
    cos_in = quant(AMP * $cos(a));
  endtask

  task automatic step(input real th, input real nxt, input int mode, input real rate,
                      input real tol, input string req);
    @(negedge clk);
    put(th);
    in_valid = 1'b1;
    q_ang.push_back(nxt);
    q_mode.push_back(mode);
    q_rate.push_back(rate);
    q_tol.push_back(tol);
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic hold_at(input real th, input string req);
    for (int i = 0; i < 1800; i++)
      step(th, th, (i == 1799) ? 3 : ((i >= 1600) ? 1 : 0), 0.0, 1.0, req);
  endtask

  task automatic ramp(input real start, input real rate, input int n, input int lock_mode,
                      input string req);
    for (int i = 0; i < n; i++) begin
      real th = start + rate * i;
      int m = 0;
      if (i >= n - 1000) m = lock_mode;
      if (i == n - 1) m = lock_mode | 2;
      step(th, th + rate, m, rate, 0.25, req);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (out_valid) begin
      if (q_ang.size() == 0) begin
        chk(1'b0, "R4", "out_valid without pending sample", 1.0, 0.0);
      end else begin
        real e_ang = q_ang.pop_front();
        int m = q_mode.pop_front();
        real e_rate = q_rate.pop_front();
        real tol = q_tol.pop_front();
        string req = q_req.pop_front();
        if (m[0]) begin
          real d = wrapd(real'(angle_out) - e_ang);
          chk(fabs(d) < 2.0, req, "angle lock", real'(angle_out), e_ang);
        end
        if (m[1]) begin
          real v = real'(velocity_out) / 65536.0;
          chk(fabs(v - e_rate) < tol, req, "velocity", v, e_rate);
        end
        if (m[2] && have_prev) begin
          real dd = wrapd(real'(angle_out) - real'(prev_ang));
          chk(fabs(dd) <= 1.0, "R8", "step between outputs", dd, 1.0);
        end
        if (have_prev && ((int'(angle_out) - int'(prev_ang) > 2048) ||
                          (int'(prev_ang) - int'(angle_out) > 2048)))
          wraps++;
        prev_ang = angle_out;
        have_prev = 1'b1;
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] a0;
    logic signed [VW-1:0] v0;
    real cur;
    int w0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(angle_out == '0, "R1", "angle after reset", real'(angle_out), 0.0);
    chk(velocity_out == '0, "R1", "velocity after reset", real'(velocity_out), 0.0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", real'(out_valid), 0.0);
    rst = 1'b0;

    // R5 fixed angles, including half a turn away and off-grid
    hold_at(1000.0, "R5");
    hold_at(3000.0, "R5");
    hold_at(2047.5, "R5");
    hold_at(4000.0, "R5");
    idle(3);

    // R2 inputs ignored while strobe low
    a0 = angle_out;
    v0 = velocity_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      put(500.0 + 37.0 * i);
      in_valid = 1'b0;
    end
    @(negedge clk);
    chk(angle_out == a0, "R2", "angle held", real'(angle_out), real'(a0));
    chk(velocity_out == v0, "R2", "velocity held", real'(velocity_out), real'(v0));
    chk(out_valid == 1'b0, "R4", "out_valid low without strobe", real'(out_valid), 0.0);

    // R4 one-cycle valid
    step(4000.0, 4000.0, 0, 0.0, 1.0, "R4");
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R4", "out_valid after strobe", real'(out_valid), 1.0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid drops", real'(out_valid), 0.0);

    // R3 positive error probe
    a0 = angle_out;
    v0 = velocity_out;
    step(4200.0, 4200.0, 0, 0.0, 1.0, "R3");
    @(negedge clk);
    in_valid = 1'b0;
    chk(velocity_out > v0, "R3", "velocity rises on positive error",
        real'(velocity_out), real'(v0));
    chk(wrapd(real'(angle_out) - real'(a0)) > 0.0, "R3", "angle moves forward",
        real'(angle_out), real'(a0));
    hold_at(4000.0, "R5");
    idle(2);

    // R3 negative error probe
    a0 = angle_out;
    v0 = velocity_out;
    step(3800.0, 3800.0, 0, 0.0, 1.0, "R3");
    @(negedge clk);
    in_valid = 1'b0;
    chk(velocity_out < v0, "R3", "velocity falls on negative error",
        real'(velocity_out), real'(v0));
    chk(wrapd(real'(angle_out) - real'(a0)) < 0.0, "R3", "angle moves backward",
        real'(angle_out), real'(a0));
    hold_at(4000.0, "R5");

    // R6 / R7 forward ramp crossing zero
    w0 = wraps;
    cur = 4000.0;
    ramp(cur, 3.3, 3000, 1, "R6");
    cur = cur + 3.3 * 3000;
    idle(2);
    chk(wraps > w0, "R7", "forward wrap seen", real'(wraps - w0), 1.0);

    // R6 / R7 reverse ramp crossing zero
    w0 = wraps;
    ramp(cur, -2.7, 3000, 1, "R6");
    cur = cur - 2.7 * 3000;
    idle(2);
    chk(wraps > w0, "R7", "reverse wrap seen", real'(wraps - w0), 1.0);

    // R8 slow rotation
    ramp(cur, 0.3, 2000, 5, "R8");

    // R1 reset mid-run dominates strobe
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    put(700.0);
    @(negedge clk);
    chk(angle_out == '0, "R1", "angle after mid-run reset", real'(angle_out), 0.0);
    chk(velocity_out == '0, "R1", "velocity after mid-run reset", real'(velocity_out), 0.0);
    chk(out_valid == 1'b0, "R1", "out_valid after mid-run reset", real'(out_valid), 0.0);
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);
    finish_run();
  end
endmodule